// File: doc/BRIEF.md
# Polarity-Invertible GPIO Port Register Bank

This block is an eight-line general-purpose I/O port behind a small register interface. A host selects one of four byte-wide registers with a two-bit pointer, writes through a single-cycle write strobe, and reads through a single-cycle read strobe. Read data appears on the cycle after the strobe and then holds. The four registers are:

- the input snapshot;
- the output value;
- a per-line read-back inversion mask;
- a per-line direction mask.

On the pin side the block gives each line an output enable and an output value, and it takes the sampled pin levels as an input. The direction mask turns each line's driver on or off. Pin levels are sampled only when the host reads the input register. The sampled byte is returned XORed with the inversion mask. Line 0 is open-drain: it can only pull low or release. Lines 1 to 7 are push-pull.

The serial bus framing, address matching, pads and protection are outside the block. A surrounding bus slave drives the pointer and the strobes.

Top module: `pinbank_top`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a clock edge, the output register becomes 0x00, the inversion mask 0xF0, the direction mask 0xFF and `rd_data` 0x00. Every `pin_oe` bit is therefore 0 after reset.
- R2: Pointer values select registers as follows: 0 = input snapshot, 1 = output value, 2 = inversion mask, 3 = direction mask.
- R3: A write strobe with pointer 1, 2 or 3 stores `wr_data` in that register at the clock edge. A later read of the same pointer returns the stored byte with no inversion.
- R4: A write strobe with pointer 0 changes no register and no pin output.
- R5: For lines 1 to 7, direction bit 1 makes the line an input (`pin_oe` 0). Direction bit 0 makes it an output (`pin_oe` 1). `pin_out` carries the output register bit.
- R6: Line 0 never drives high: `pin_out[0]` is always 0. `pin_oe[0]` is 1 only when direction bit 0 is 0 and output bit 0 is 0.
- R7: A read of pointer 0 returns `pin_in`, as sampled at the strobe's clock edge, XORed bit by bit with the inversion mask.
- R8: Pin levels are captured only on a read strobe to pointer 0. Later changes on `pin_in` do not alter `rd_data` until the next read.
- R9: `rd_data` changes only at the clock edge that samples a read strobe. The new value is visible in the cycle after the strobe. Without a strobe, `rd_data` holds.
- R10: Asserting reset in the middle of operation restores every default listed in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register pointer |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 8 | Sampled pin levels |
| pin_oe | output | 8 | Per-line output enable, 1 = driving |
| pin_out | output | 8 | Per-line output value |

## Verification
The assertions check several behaviours on every cycle:

- line 0 never drives high while enabled;
- `rd_data` holds whenever no read strobe was sampled;
- a pointer-0 write leaves all three stored registers unchanged;
- a direction write is reflected on the push-pull enables one cycle later;
- an input read returns the sampled pins XOR the mask;
- reset clears the outputs.

Only the bench scenarios can show the rest:

- the full pointer map and write-then-read round trips without inversion;
- the open-drain enable rule across both output values;
- a snapshot that holds while `pin_in` moves afterwards;
- recovery of every default after a reset in mid-operation.

// File: rtl/pinbank_pkg.sv
// Package: shared constants and the register pointer encoding for the
// GPIO register bank. Assumes a two-bit pointer and byte-wide registers.
package pinbank_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        SEL_SNAP = 2'd0,
        SEL_OUTV = 2'd1,
        SEL_INVM = 2'd2,
        SEL_DIRM = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pinbank_regs.sv
// Module: holds the output value, inversion mask and direction mask.
// Assumes single-cycle write strobes. Pointer 0 (snapshot) is read-only, so a
// write to it is dropped. Reset is synchronous and active low.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int          W       = PORT_W,
    parameter logic [W-1:0] OUT_RST = 8'h00,
    parameter logic [W-1:0] INV_RST = 8'hF0,
    parameter logic [W-1:0] DIR_RST = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] outv_q,
    output logic [W-1:0] invm_q,
    output logic [W-1:0] dirm_q
);

    // Update the three writable registers on a write strobe to their pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outv_q <= OUT_RST;
            invm_q <= INV_RST;
            dirm_q <= DIR_RST;
        end else if (wr_en) begin
            case (sel)
                SEL_OUTV: outv_q <= wr_data;
                SEL_INVM: invm_q <= wr_data;
                SEL_DIRM: dirm_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // R4: a write aimed at the read-only pointer leaves every register alone
    a_r4_snap_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SNAP) |=> ($stable(outv_q) && $stable(invm_q) && $stable(dirm_q)));

endmodule

// File: rtl/pinbank_read.sv
// Module: read path. Samples the pins on a read of pointer 0 and applies the
// inversion mask. The read register doubles as the input snapshot register.
// Assumes single-cycle read strobes. Data is valid the cycle after the strobe
// and holds until the next strobe.
module pinbank_read
    import pinbank_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         rd_en,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] outv_q,
    input  logic [W-1:0] invm_q,
    input  logic [W-1:0] dirm_q,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] rd_next;

    // Select the byte the current pointer returns; only the snapshot is inverted.
    always_comb begin
        case (sel)
            SEL_SNAP: rd_next = pin_in ^ invm_q;
            SEL_OUTV: rd_next = outv_q;
            SEL_INVM: rd_next = invm_q;
            default:  rd_next = dirm_q;
        endcase
    end

    // Capture the selected byte only at a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    // R7: an input read returns the sampled pins XOR the (unchanged) mask
    a_r7_snap_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_SNAP) |=> (rd_data == ($past(pin_in) ^ $past(invm_q))));

    // R9: without a strobe the read data holds
    a_r9_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> $stable(rd_data));

endmodule

// File: rtl/pinbank_drive.sv
// Module: per-line pin drive. OD_MASK picks the lines built as open-drain;
// those lines only pull low or release. All other lines are push-pull.
// Assumes direction bit 1 means input.
module pinbank_drive
    import pinbank_pkg::*;
#(
    parameter int           W       = PORT_W,
    parameter logic [W-1:0] OD_MASK = 8'h01
) (
    input  logic [W-1:0] outv_q,
    input  logic [W-1:0] dirm_q,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);

    // Build each line as open-drain or push-pull according to OD_MASK.
    for (genvar i = 0; i < W; i++) begin : g_line
        if (OD_MASK[i]) begin : g_od
            assign pin_oe[i]  = ~dirm_q[i] & ~outv_q[i];
            assign pin_out[i] = 1'b0;
        end else begin : g_pp
            assign pin_oe[i]  = ~dirm_q[i];
            assign pin_out[i] = outv_q[i];
        end
    end

endmodule

// File: rtl/pinbank_top.sv
// Module: top of the GPIO register bank. Wires the register file, the read
// path and the pin drive together. Assumes the host holds the pointer stable
// during each strobe. Reset is synchronous and active low.
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int           W       = PORT_W,
    parameter logic [W-1:0] OUT_RST = 8'h00,
    parameter logic [W-1:0] INV_RST = 8'hF0,
    parameter logic [W-1:0] DIR_RST = 8'hFF,
    parameter logic [W-1:0] OD_MASK = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   reg_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);

    logic [W-1:0] outv_q;
    logic [W-1:0] invm_q;
    logic [W-1:0] dirm_q;

    pinbank_regs #(
        .W(W), .OUT_RST(OUT_RST), .INV_RST(INV_RST), .DIR_RST(DIR_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .outv_q(outv_q), .invm_q(invm_q), .dirm_q(dirm_q)
    );

    pinbank_read #(.W(W)) u_read (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .rd_en(rd_en), .pin_in(pin_in),
        .outv_q(outv_q), .invm_q(invm_q), .dirm_q(dirm_q), .rd_data(rd_data)
    );

    pinbank_drive #(.W(W), .OD_MASK(OD_MASK)) u_drive (
        .outv_q(outv_q), .dirm_q(dirm_q), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // R6: line 0 never drives a high level
    a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[0] |-> !pin_out[0]);

    // R5: a direction write shows on the push-pull enables one cycle later
    a_r5_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_DIRM) |=> (pin_oe[W-1:1] == ~$past(wr_data[W-1:1])));

    // R1: reset releases every line and clears the read data
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && rd_data == '0));

endmodule

// File: tb/pinbank_top_test.sv
// Bench for pinbank_top: a vector table walked by one loop, then directed
// tests for reset, ignored writes, open-drain behaviour and snapshot timing.
module pinbank_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // Each entry is {pointer, data, expected read}. Pointer 0 puts the data on
    // the pins and reads; other pointers write the data and read it back.
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 8'h3C, 8'hCC},
        {2'd2, 8'h00, 8'h00},
        {2'd0, 8'hA5, 8'hA5},
        {2'd2, 8'hFF, 8'hFF},
        {2'd0, 8'h5A, 8'hA5},
        {2'd1, 8'h81, 8'h81},
        {2'd3, 8'h0F, 8'h0F},
        {2'd2, 8'h0F, 8'h0F},
        {2'd0, 8'hFF, 8'hF0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;

    pinbank_top uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_defaults(input string tag);
        logic [7:0] v;
        check({tag, " rd_data"}, rd_data, 8'h00);
        check({tag, " pin_oe"}, pin_oe, 8'h00);
        do_read(2'd1, v); check({tag, " output reg"}, v, 8'h00);
        do_read(2'd2, v); check({tag, " inversion"}, v, 8'hF0);
        do_read(2'd3, v); check({tag, " direction"}, v, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: defaults after reset
        check_defaults("R1");

        // R2 R3 R7: table walk over the pointer map
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][17:16] == 2'd0) begin
                pin_in = VEC[i][15:8];
                do_read(2'd0, got);
                check("R7 snapshot xor mask", got, VEC[i][7:0]);
            end else begin
                do_write(VEC[i][17:16], VEC[i][15:8]);
                do_read(VEC[i][17:16], got);
                check("R2 R3 write read-back", got, VEC[i][7:0]);
            end
        end
        // R5: out=0x81, dir=0x0F gives lines 4-7 enabled and pin_out=0x80
        check("R5 enables", pin_oe, 8'hF0);
        check("R5 values", pin_out, 8'h80);

        // R4: a write to pointer 0 is dropped
        do_write(2'd0, 8'h55);
        do_read(2'd1, got); check("R4 output reg kept", got, 8'h81);
        do_read(2'd2, got); check("R4 inversion kept", got, 8'h0F);
        do_read(2'd3, got); check("R4 direction kept", got, 8'h0F);
        check("R4 pins kept", pin_oe, 8'hF0);

        // R6: line 0 is open-drain
        do_write(2'd1, 8'h00);
        do_write(2'd3, 8'hFE);
        check("R6 low pull enable", pin_oe, 8'h01);
        check("R6 low pull value", pin_out, 8'h00);
        do_write(2'd1, 8'h01);
        check("R6 release enable", pin_oe, 8'h00);
        check("R6 release value", {7'd0, pin_out[0]}, 8'h00);
        do_write(2'd3, 8'h00);
        do_write(2'd1, 8'hFF);
        check("R5 R6 all outputs enable", pin_oe, 8'hFE);
        check("R5 R6 all outputs value", pin_out, 8'hFE);

        // R9: the strobe cycle still shows old data, the next cycle the new
        do_read(2'd3, got);
        @(negedge clk);
        pin_in = 8'h33; reg_sel = 2'd0; rd_en = 1'b1;
        #1 check("R9 old data during strobe", rd_data, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 R7 new data after strobe", rd_data, 8'h3C);

        // R8: later pin changes do not reach the snapshot
        pin_in = 8'hCC;
        repeat (3) @(negedge clk);
        check("R8 snapshot holds", rd_data, 8'h3C);
        do_read(2'd0, got);
        check("R8 next read recaptures", got, 8'hC3);

        // R10: reset during operation
        do_reset();
        check_defaults("R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule